// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle Insertion

This block shifts characters out on a single serial line, one bit per pulse of an externally supplied bit-rate tick. A data character has a low start bit, eight or nine data bits sent least significant first, and a high stop bit. The line can also carry two kinds of special character: a break, which holds the line low for longer than a full frame, and an idle, which holds it high for exactly one frame length.

Software-side logic feeds characters through a one-entry holding buffer. A flag shows when that buffer is empty, and a second flag shows that the transmitter has nothing left to send. Three controls shape the line traffic:

- A level-sensitive break request queues break characters.
- Dropping the transmit enable and raising it again while a character is on the line queues one idle character.
- Clearing the transmit enable makes the block finish everything it already holds before it gives up the pin. It signals this by dropping its output enable.

A single-wire option lets a direction input decide whether the shared line is driven at all.

Top module: `uart_tx_queue`

## Requirements
- R1: After reset the line is high, the output enable is low, and both the buffer-empty flag and the done flag are high.
- R2: In 8-bit mode a character takes 10 consecutive ticks. The line reads 0 for the first tick, then data bit 0 through bit 7, then 1. Each tick advances exactly one bit. With no work pending the line stays at 1.
- R3: In 9-bit mode the character takes 11 ticks: 0, data bits 0 through 8, then 1.
- R4: A write is taken only in a cycle where the transmitter is enabled and the buffer is empty. Taking it clears the buffer-empty flag. The flag sets again on the tick that moves the word into the shifter. A write made while the buffer is full is dropped.
- R5: If a word is buffered, it starts on the same tick that ends the previous character, with no gap between frames.
- R6: A single break request pulse sends one break: 10 ticks of 0 in 8-bit mode or 11 in 9-bit mode. The long-break option adds 3 ticks to either length.
- R7: The break request is sampled every cycle while enabled. A request still high on the tick that starts a break queues another break, so a request held across the start of the first break gives 20 zero ticks in 8-bit mode.
- R8: A low-then-high pulse on the transmit enable during a character queues one idle character, which is one frame length of 1. The done flag therefore rises 20 ticks after the data character starts instead of 10.
- R9: When several items are pending, the buffered word goes first, then a break, then an idle.
- R10: With the enable low, writes and break requests are dropped. The output enable stays high until the last held character has finished, and falls on the clock after the tick that ends it.
- R11: The done flag is high exactly when the shifter, the buffer and both special-character queues are all empty.
- R12: In single-wire mode the output enable is forced low unless the direction input is 1. Outside single-wire mode the direction input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Break request (level) |
| long_brk | input | 1 | Adds 3 bit times to each break |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| one_wire | input | 1 | Single-wire mode select |
| wire_dir | input | 1 | Drive direction in single-wire mode (1 = drive) |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Write data (bit 8 is used only in 9-bit mode) |
| tx_out | output | 1 | Serial line value |
| tx_oe | output | 1 | Output enable for the serial line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Nothing in flight or pending |

## Verification
Some rules are checked by the assertions on every cycle:
- the line is high whenever the shifter is idle;
- a break shows only 0 and an idle only 1;
- the shifter moves only on a tick;
- a buffered word stays stable until it is taken;
- an idle is never taken ahead of a pending break;
- the output enable is high whenever a character is on the line and falls only when the done flag is set.

Other behaviour can only be shown by the bench scenarios:
- exact frame contents for every data value in both widths;
- break and idle lengths;
- the second break that a held request produces;
- the order in which mixed pending work leaves the shifter;
- the exact cycle at which the pin is released after the enable is cleared.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    typedef enum logic [1:0] {
        ITEM_NONE = 2'd0,
        ITEM_DATA = 2'd1,
        ITEM_BRK  = 2'd2,
        ITEM_IDLE = 2'd3
    } item_e;
endpackage

// File: rtl/txq_holdbuf.sv
module txq_holdbuf #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hb_t;

    hb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (wr_valid && en && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign data = st_q.data;

    // R4: a buffered word is held unchanged until the shifter takes it
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !take) |=> (st_q.full && $stable(st_q.data)))
        else $error("buffer word changed before take");

    // R4: the shifter takes only from a full buffer
    p_take_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.full)
        else $error("take from empty buffer");
endmodule

// File: rtl/txq_specq.sv
module txq_specq (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic brk_req,
    input  logic busy,
    input  logic take_brk,
    input  logic take_idle,
    output logic brk_pend,
    output logic idle_pend
);
    typedef struct packed {
        logic brk;
        logic idle;
        logic en_prev;
    } sq_t;

    sq_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.brk     = (st_q.brk  && !take_brk)  || (brk_req && tx_en);
        st_d.idle    = (st_q.idle && !take_idle) || (tx_en && !st_q.en_prev && busy);
        st_d.en_prev = tx_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_pend  = st_q.brk;
    assign idle_pend = st_q.idle;

    // R7: a break is taken only when one is queued
    p_brk_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_brk |-> st_q.brk)
        else $error("break taken with none queued");

    // R9: an idle is never taken ahead of a pending break
    p_idle_after_brk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_idle |-> (st_q.idle && !st_q.brk))
        else $error("idle taken ahead of break");
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
    import uart_txq_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int BRK_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              nine_bit,
    input  logic              long_brk,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              brk_pend,
    input  logic              idle_pend,
    output logic              take_data,
    output logic              take_brk,
    output logic              take_idle,
    output logic              busy,
    output logic              line
);
    localparam int SH_W    = DATA_W + 2;
    localparam int CNT_MAX = SH_W + BRK_EXTRA;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic            busy;
        logic            fill;
        item_e           kind;
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0] sh;
    } sf_t;

    sf_t st_d, st_q;
    logic [CNT_W-1:0] frame_len;
    logic             advance;
    logic [SH_W-1:0]  data_frame;

    always_comb begin
        frame_len = nine_bit ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
        advance   = bit_tick && (!st_q.busy || st_q.cnt == CNT_W'(1));
        take_data = advance && buf_full;
        take_brk  = advance && !buf_full && brk_pend;
        take_idle = advance && !buf_full && !brk_pend && idle_pend;

        data_frame = {1'b1, buf_data, 1'b0};
        if (!nine_bit) data_frame[DATA_W] = 1'b1;

        st_d = st_q;
        if (bit_tick && st_q.busy && st_q.cnt > CNT_W'(1)) begin
            st_d.sh  = {st_q.fill, st_q.sh[SH_W-1:1]};
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (advance) begin
            if (take_data) begin
                st_d.busy = 1'b1;
                st_d.kind = ITEM_DATA;
                st_d.fill = 1'b1;
                st_d.sh   = data_frame;
                st_d.cnt  = frame_len;
            end else if (take_brk) begin
                st_d.busy = 1'b1;
                st_d.kind = ITEM_BRK;
                st_d.fill = 1'b0;
                st_d.sh   = '0;
                st_d.cnt  = frame_len + (long_brk ? CNT_W'(BRK_EXTRA) : CNT_W'(0));
            end else if (take_idle) begin
                st_d.busy = 1'b1;
                st_d.kind = ITEM_IDLE;
                st_d.fill = 1'b1;
                st_d.sh   = '1;
                st_d.cnt  = frame_len;
            end else begin
                st_d.busy = 1'b0;
                st_d.kind = ITEM_NONE;
                st_d.fill = 1'b1;
                st_d.sh   = '1;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.fill <= 1'b1;
            st_q.kind <= ITEM_NONE;
            st_q.sh   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.sh[0];

    // R2: an idle shifter keeps the line high
    p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> line)
        else $error("line low while idle");

    // R2: the shifter moves only on a tick
    p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(st_q.sh) && $stable(st_q.cnt)))
        else $error("shifter moved without tick");

    // R6: a break holds the line low throughout
    p_brk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.kind == ITEM_BRK) |-> !line)
        else $error("break bit not low");

    // R8: an idle character holds the line high throughout
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.kind == ITEM_IDLE) |-> line)
        else $error("idle bit not high");

    // R6: the bit counter stays within the longest character
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0 && st_q.cnt <= CNT_W'(CNT_MAX)))
        else $error("bit counter out of range");
endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue
    import uart_txq_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int BRK_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              long_brk,
    input  logic              nine_bit,
    input  logic              one_wire,
    input  logic              wire_dir,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_out,
    output logic              tx_oe,
    output logic              buf_empty,
    output logic              tx_done
);
    typedef struct packed {
        logic oe;
    } top_t;

    top_t st_d, st_q;

    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              brk_pend, idle_pend;
    logic              take_data, take_brk, take_idle;
    logic              busy, line;

    txq_holdbuf #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take_data),
        .full     (buf_full),
        .data     (buf_data)
    );

    txq_specq u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .busy      (busy),
        .take_brk  (take_brk),
        .take_idle (take_idle),
        .brk_pend  (brk_pend),
        .idle_pend (idle_pend)
    );

    txq_shifter #(.DATA_W(DATA_W), .BRK_EXTRA(BRK_EXTRA)) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .nine_bit  (nine_bit),
        .long_brk  (long_brk),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .brk_pend  (brk_pend),
        .idle_pend (idle_pend),
        .take_data (take_data),
        .take_brk  (take_brk),
        .take_idle (take_idle),
        .busy      (busy),
        .line      (line)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = tx_en || busy || buf_full || brk_pend || idle_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_out    = line;
    assign tx_oe     = st_q.oe && (!one_wire || wire_dir);
    assign buf_empty = !buf_full;
    assign tx_done   = !busy && !buf_full && !brk_pend && !idle_pend;

    // R10: the pin is owned whenever a character is on the line
    p_own_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> st_q.oe)
        else $error("character sent without pin ownership");

    // R10: the pin is released only once all work has drained
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.oe) |-> tx_done)
        else $error("pin released with work pending");

    // R11: when done, the line is idle high
    p_done_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_out)
        else $error("done flag with line low");
endmodule

// File: tb/uart_tx_queue_tb.sv
module uart_tx_queue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       long_brk = 1'b0;
    logic       nine_bit = 1'b0;
    logic       one_wire = 1'b0;
    logic       wire_dir = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_out, tx_oe, buf_empty, tx_done;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    uart_tx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .brk_req(brk_req), .long_brk(long_brk), .nine_bit(nine_bit),
        .one_wire(one_wire), .wire_dir(wire_dir), .wr_valid(wr_valid),
        .wr_data(wr_data), .tx_out(tx_out), .tx_oe(tx_oe),
        .buf_empty(buf_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick(output logic b);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        b = tx_out;
    endtask

    task automatic write(input logic [8:0] d);
        @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
        @(negedge clk) wr_valid = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) brk_req = 1'b0;
    endtask

    task automatic toggle_en();
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
    endtask

    task automatic count_zeros(output int z);
        logic b;
        z = 0;
        for (int i = 0; i < 60; i++) begin
            do_tick(b);
            if (b) break;
            z++;
        end
    endtask

    task automatic ticks_to_done(output int n);
        logic b;
        n = 0;
        while (!tx_done && n < 80) begin
            do_tick(b);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic        b;
        logic [11:0] fr;
        logic [20:0] v21;
        logic [29:0] v30;
        int          z, n;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_out == 1'b1 && tx_oe == 1'b0 && buf_empty && tx_done, "R1 reset",
            {tx_out, tx_oe, buf_empty, tx_done}, 4'b1011);
        rst_n = 1'b1;
        @(negedge clk) tx_en = 1'b1;
        repeat (2) @(negedge clk);

        // R2 sweep over all 8-bit values
        nine_bit = 1'b0;
        for (int v = 0; v < 256; v++) begin
            write(9'(v));
            for (int i = 0; i < 11; i++) begin do_tick(b); fr[i] = b; end
            chk(fr[10:0] == {2'b11, 8'(v), 1'b0}, "R2 8-bit frame", fr[10:0], {2'b11, 8'(v), 1'b0});
        end

        // R3 sweep over all 9-bit values
        nine_bit = 1'b1;
        for (int v = 0; v < 512; v++) begin
            write(9'(v));
            for (int i = 0; i < 12; i++) begin do_tick(b); fr[i] = b; end
            chk(fr == {2'b11, 9'(v), 1'b0}, "R3 9-bit frame", fr, {2'b11, 9'(v), 1'b0});
        end
        nine_bit = 1'b0;

        // R4 buffer flag and write-while-full drop; R11 done low with word buffered
        write(9'h0A5);
        chk(buf_empty == 1'b0, "R4 empty clears on write", buf_empty, 0);
        chk(tx_done == 1'b0, "R11 done low with buffered word", tx_done, 0);
        write(9'h03C);
        do_tick(b); v21[0] = b;
        chk(buf_empty == 1'b1, "R4 empty sets on load", buf_empty, 1);
        for (int i = 1; i < 21; i++) begin do_tick(b); v21[i] = b; end
        chk(v21 == {11'h7FF, 1'b1, 8'hA5, 1'b0}, "R4 write while full dropped",
            v21, {11'h7FF, 1'b1, 8'hA5, 1'b0});

        // R5 back-to-back frames
        write(9'h0C3);
        do_tick(b); v21[0] = b;
        write(9'h05A);
        for (int i = 1; i < 21; i++) begin do_tick(b); v21[i] = b; end
        chk(v21 == {1'b1, 1'b1, 8'h5A, 1'b0, 1'b1, 8'hC3, 1'b0}, "R5 back-to-back",
            v21, {1'b1, 1'b1, 8'h5A, 1'b0, 1'b1, 8'hC3, 1'b0});
        chk(tx_done == 1'b1, "R11 done after drain", tx_done, 1);

        // R6 break lengths in each width and length option
        for (int nb = 0; nb < 2; nb++) begin
            for (int lb = 0; lb < 2; lb++) begin
                nine_bit = nb[0]; long_brk = lb[0];
                pulse_brk();
                chk(tx_done == 1'b0, "R11 done low with break queued", tx_done, 0);
                count_zeros(z);
                chk(z == (nb ? 11 : 10) + (lb ? 3 : 0), "R6 break length", z, (nb ? 11 : 10) + (lb ? 3 : 0));
            end
        end
        nine_bit = 1'b0; long_brk = 1'b0;

        // R7 held request queues a second break
        @(negedge clk) brk_req = 1'b1;
        do_tick(b);
        brk_req = 1'b0;
        z = b ? 0 : 1;
        if (!b) begin count_zeros(n); z += n; end
        chk(z == 20, "R7 held break repeats", z, 20);

        // R8 idle via enable toggle, and its control case
        write(9'h011);
        do_tick(b);
        ticks_to_done(n);
        chk(n == 10, "R8 no idle without toggle", n, 10);
        write(9'h011);
        do_tick(b);
        toggle_en();
        ticks_to_done(n);
        chk(n == 20, "R8 idle frame queued", n, 20);

        // R9 priority: data, then break, then idle
        write(9'h0F0);
        do_tick(b); v30[0] = b;
        write(9'h00F);
        pulse_brk();
        toggle_en();
        for (int i = 1; i < 30; i++) begin do_tick(b); v30[i] = b; end
        chk(v30 == {10'h000, 1'b1, 8'h0F, 1'b0, 1'b1, 8'hF0, 1'b0}, "R9 data before break",
            v30, {10'h000, 1'b1, 8'h0F, 1'b0, 1'b1, 8'hF0, 1'b0});
        ticks_to_done(n);
        chk(n == 11, "R9 idle last", n, 11);

        // R10 drain on disable
        write(9'h066);
        do_tick(b); fr[0] = b;
        @(negedge clk) tx_en = 1'b0;
        write(9'h099);
        pulse_brk();
        chk(tx_oe == 1'b1, "R10 pin held while draining", tx_oe, 1);
        for (int i = 1; i < 10; i++) begin do_tick(b); fr[i] = b; end
        chk(tx_oe == 1'b1, "R10 pin held to last bit", tx_oe, 1);
        do_tick(b); fr[10] = b;
        chk(fr[10:0] == {2'b11, 8'h66, 1'b0}, "R10 drained frame", fr[10:0], {2'b11, 8'h66, 1'b0});
        @(negedge clk);
        chk(tx_oe == 1'b0, "R10 pin released", tx_oe, 0);
        chk(buf_empty && tx_done, "R10 disabled write and break dropped", {buf_empty, tx_done}, 2'b11);
        z = 0;
        for (int i = 0; i < 12; i++) begin do_tick(b); if (!b) z++; end
        chk(z == 0, "R10 no break sent while disabled", z, 0);
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        chk(tx_oe == 1'b1, "R10 pin taken on enable", tx_oe, 1);

        // R12 single-wire direction
        @(negedge clk) begin one_wire = 1'b1; wire_dir = 1'b0; end
        #1 chk(tx_oe == 1'b0, "R12 single-wire receive", tx_oe, 0);
        @(negedge clk) wire_dir = 1'b1;
        #1 chk(tx_oe == 1'b1, "R12 single-wire drive", tx_oe, 1);
        @(negedge clk) begin one_wire = 1'b0; wire_dir = 1'b0; end
        #1 chk(tx_oe == 1'b1, "R12 direction ignored outside single-wire", tx_oe, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule